// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the memory operand address of an instruction from its already decoded addressing fields. The caller presents the two-bit mode field, the three-bit register/memory field, the three scaled-index fields, a raw displacement word and the current contents of the eight general registers. It also sets a flag that chooses between the 16-bit and the 32-bit addressing forms. One clock later the unit returns the offset inside the segment. It also returns the default segment, which is the stack segment or the data segment. A flag tells the caller that the operand is a register, and in that case no address is formed.

The unit does not add a segment base and does not check limits. A segment override prefix is applied by the caller after the result appears. All inputs are sampled on the clock edge at which `in_valid` is high. Between requests the outputs keep the last result.

Top module: `ea_gen`

## Requirements
- R1: A request accepted with `in_valid` high at one rising edge gives `out_valid` high, with its result on `ea`, `seg_ss` and `is_reg`, after that edge and until the next edge.
- R2: In 16-bit form (`addr32`=0) the r/m codes 0..7 take the register sums BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. These use the low 16 bits of the registers at `gpr_flat` slots 3 (BX), 5 (BP), 6 (SI) and 7 (DI).
- R3: In 16-bit form, mode 00 with r/m 110 gives the low 16 bits of `disp` as the address, with no register added, and selects the data segment.
- R4: Mode 01 adds `disp[7:0]` sign-extended to the address width. Mode 10 adds `disp[15:0]` in 16-bit form and the whole of `disp` in 32-bit form. Mode 00 adds no displacement, except in the direct cases of R3, R6 and R8.
- R5: A 16-bit result wraps modulo 2^16, and `ea[31:16]` is zero.
- R6: In 32-bit form, r/m codes other than 100 select register slot r/m as the base (slot order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI at bits 32n+31:32n). Mode 00 with r/m 101 uses the whole of `disp` with no base.
- R7: With r/m 100 in 32-bit form, the index register at slot `sib_index` is multiplied by 1, 2, 4 or 8 for `sib_scale` 00, 01, 10 or 11. An index code of 100 adds no index.
- R8: With r/m 100, a `sib_base` of 101 in mode 00 means no base plus the whole of `disp`. In modes 01 and 10 it means EBP plus the displacement. Any other base code selects that slot.
- R9: `seg_ss` is 1 when the base is BP (16-bit form) or when the base is EBP or ESP (32-bit form). It is 0 in every other case.
- R10: Mode 11 in either form gives `is_reg`=1, `ea`=0 and `seg_ss`=0. Every memory form gives `is_reg`=0.
- R11: A 32-bit result wraps modulo 2^32.
- R12: An edge with `in_valid` low leaves `out_valid` low after it, and `ea`, `seg_ss` and `is_reg` unchanged, whatever the other inputs are doing.
- R13: While `rst` is high at a rising edge, the outputs become `out_valid`=0, `ea`=0, `seg_ss`=0 and `is_reg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| addr32 | input | 1 | 1 selects the 32-bit form, 0 the 16-bit form |
| mod_f | input | 2 | Mode field |
| rm_f | input | 3 | Register/memory field |
| sib_scale | input | 2 | Index scale code |
| sib_index | input | 3 | Index register code |
| sib_base | input | 3 | Base register code |
| disp | input | 32 | Raw displacement, right aligned |
| gpr_flat | input | 256 | Eight 32-bit registers, slot n at bits 32n+31:32n |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address (segment offset) |
| seg_ss | output | 1 | 1 for the stack segment, 0 for the data segment |
| is_reg | output | 1 | Operand is a register, no address formed |

## Verification
The bench builds the unit with the package defaults: 32-bit registers and eight register slots. At that size the register file can hold values whose upper halves are nonzero and whose low halves overflow when added. This makes the 16-bit truncation and wrap, the 8-bit sign extension and the 32-bit carry-out wrap visible in the result. The bench sweeps every mode and r/m code in both forms, and every scale and index code against the base codes that have special meaning. Sweeping every scale and index code this way reaches each escape of the scaled-index form.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int REG_W  = 32;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int HALF_W = REG_W / 2;
    localparam int BANK_W = REG_W * NREG;

    typedef logic [REG_W-1:0]             word_t;
    typedef logic [HALF_W-1:0]            half_t;
    typedef logic [RIDX_W-1:0]            ridx_t;
    typedef logic [NREG-1:0][REG_W-1:0]   gpr_bank_t;

    typedef enum logic {
        SEG_DS = 1'b0,
        SEG_SS = 1'b1
    } seg_e;

    typedef enum logic [1:0] {
        MOD_NODISP = 2'b00,
        MOD_DISP8  = 2'b01,
        MOD_DISPW  = 2'b10,
        MOD_REG    = 2'b11
    } mod_e;

    // register slot numbers that carry special meaning
    localparam ridx_t SLOT_SP = 3'd4;
    localparam ridx_t SLOT_BP = 3'd5;
    localparam ridx_t SLOT_BX = 3'd3;
    localparam ridx_t SLOT_SI = 3'd6;
    localparam ridx_t SLOT_DI = 3'd7;

    // field codes with special meaning
    localparam logic [2:0] RM_ESCAPE = 3'b100;
    localparam logic [2:0] RM_DIRECT = 3'b101;
    localparam logic [2:0] RM16_DIR  = 3'b110;
    localparam logic [2:0] IDX_NONE  = 3'b100;

    typedef struct packed {
        word_t addr;
        seg_e  seg;
        logic  is_reg;
    } ea_res_t;

    function automatic word_t sext8_w(input logic [7:0] b);
        return {{(REG_W-8){b[7]}}, b};
    endfunction

    function automatic half_t sext8_h(input logic [7:0] b);
        return {{(HALF_W-8){b[7]}}, b};
    endfunction

endpackage

// File: rtl/ea_form16.sv
module ea_form16
    import ea_pkg::*;
(
    input  mod_e       mode,
    input  logic [2:0] rm,
    input  half_t      disp16,
    input  half_t      bx_v,
    input  half_t      bp_v,
    input  half_t      si_v,
    input  half_t      di_v,
    output ea_res_t    res
);

    half_t base_v;
    half_t idx_v;
    half_t dsp_v;
    half_t sum_v;
    logic  via_bp;

    always_comb begin
        base_v = '0;
        idx_v  = '0;
        via_bp = 1'b0;
        unique case (rm)
            3'b000: begin base_v = bx_v; idx_v = si_v; end
            3'b001: begin base_v = bx_v; idx_v = di_v; end
            3'b010: begin base_v = bp_v; idx_v = si_v; via_bp = 1'b1; end
            3'b011: begin base_v = bp_v; idx_v = di_v; via_bp = 1'b1; end
            3'b100: begin idx_v = si_v; end
            3'b101: begin idx_v = di_v; end
            3'b110: begin
                if (mode != MOD_NODISP) begin
                    base_v = bp_v;
                    via_bp = 1'b1;
                end
            end
            default: begin base_v = bx_v; end
        endcase
    end

    always_comb begin
        unique case (mode)
            MOD_NODISP: dsp_v = (rm == RM16_DIR) ? disp16 : '0;
            MOD_DISP8:  dsp_v = sext8_h(disp16[7:0]);
            MOD_DISPW:  dsp_v = disp16;
            default:    dsp_v = '0;
        endcase
    end

    assign sum_v = base_v + idx_v + dsp_v;

    always_comb begin
        if (mode == MOD_REG) begin
            res.addr   = '0;
            res.seg    = SEG_DS;
            res.is_reg = 1'b1;
        end else begin
            res.addr   = {{(REG_W-HALF_W){1'b0}}, sum_v};
            res.seg    = via_bp ? SEG_SS : SEG_DS;
            res.is_reg = 1'b0;
        end
    end

endmodule

// File: rtl/ea_form32.sv
module ea_form32
    import ea_pkg::*;
(
    input  mod_e       mode,
    input  logic [2:0] rm,
    input  logic [1:0] scale,
    input  logic [2:0] idx,
    input  logic [2:0] base,
    input  word_t      disp,
    input  gpr_bank_t  gpr,
    output ea_res_t    res
);

    logic  use_sib;
    logic  no_base;
    ridx_t base_sel;
    word_t base_v;
    word_t sidx_v;
    word_t dsp_v;
    word_t sum_v;

    assign use_sib = (rm == RM_ESCAPE);

    always_comb begin
        if (use_sib) begin
            base_sel = base;
            no_base  = (base == RM_DIRECT) && (mode == MOD_NODISP);
        end else begin
            base_sel = rm;
            no_base  = (rm == RM_DIRECT) && (mode == MOD_NODISP);
        end
    end

    assign base_v = no_base ? '0 : gpr[base_sel];

    always_comb begin
        if (use_sib && (idx != IDX_NONE))
            sidx_v = gpr[idx] << scale;
        else
            sidx_v = '0;
    end

    always_comb begin
        unique case (mode)
            MOD_NODISP: dsp_v = no_base ? disp : '0;
            MOD_DISP8:  dsp_v = sext8_w(disp[7:0]);
            MOD_DISPW:  dsp_v = disp;
            default:    dsp_v = '0;
        endcase
    end

    assign sum_v = base_v + sidx_v + dsp_v;

    always_comb begin
        if (mode == MOD_REG) begin
            res.addr   = '0;
            res.seg    = SEG_DS;
            res.is_reg = 1'b1;
        end else begin
            res.addr   = sum_v;
            res.seg    = (!no_base && (base_sel == SLOT_BP || base_sel == SLOT_SP))
                         ? SEG_SS : SEG_DS;
            res.is_reg = 1'b0;
        end
    end

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage
    import ea_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid_in,
    input  ea_res_t res_in,
    output logic    valid_q,
    output ea_res_t res_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '{addr: '0, seg: SEG_DS, is_reg: 1'b0};
        end else begin
            valid_q <= valid_in;
            if (valid_in)
                res_q <= res_in;
        end
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              addr32,
    input  logic [1:0]        mod_f,
    input  logic [2:0]        rm_f,
    input  logic [1:0]        sib_scale,
    input  logic [2:0]        sib_index,
    input  logic [2:0]        sib_base,
    input  logic [REG_W-1:0]  disp,
    input  logic [BANK_W-1:0] gpr_flat,
    output logic              out_valid,
    output logic [REG_W-1:0]  ea,
    output logic              seg_ss,
    output logic              is_reg
);

    gpr_bank_t bank;
    mod_e      mode;
    ea_res_t   res16;
    ea_res_t   res32;
    ea_res_t   res_nxt;
    ea_res_t   res_q;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign bank[g] = gpr_flat[g*REG_W +: REG_W];
    end

    assign mode = mod_e'(mod_f);

    ea_form16 u_f16 (
        .mode   (mode),
        .rm     (rm_f),
        .disp16 (disp[HALF_W-1:0]),
        .bx_v   (bank[SLOT_BX][HALF_W-1:0]),
        .bp_v   (bank[SLOT_BP][HALF_W-1:0]),
        .si_v   (bank[SLOT_SI][HALF_W-1:0]),
        .di_v   (bank[SLOT_DI][HALF_W-1:0]),
        .res    (res16)
    );

    ea_form32 u_f32 (
        .mode  (mode),
        .rm    (rm_f),
        .scale (sib_scale),
        .idx   (sib_index),
        .base  (sib_base),
        .disp  (disp),
        .gpr   (bank),
        .res   (res32)
    );

    assign res_nxt = addr32 ? res32 : res16;

    ea_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .valid_in (in_valid),
        .res_in   (res_nxt),
        .valid_q  (out_valid),
        .res_q    (res_q)
    );

    assign ea     = res_q.addr;
    assign seg_ss = (res_q.seg == SEG_SS);
    assign is_reg = res_q.is_reg;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        addr32,
    input logic [1:0]  mod_f,
    input logic [2:0]  rm_f,
    input logic [2:0]  sib_index,
    input logic [2:0]  sib_base,
    input logic [31:0] disp,
    input logic        out_valid,
    input logic [31:0] ea,
    input logic        seg_ss,
    input logic        is_reg
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(ea) && $stable(seg_ss) && $stable(is_reg)));

    a_r10_reg_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mod_f == 2'b11) |=> (is_reg && ea == 32'h0 && !seg_ss));

    a_r5_wrap16: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !addr32) |=> (ea[31:16] == 16'h0));

    a_r3_direct16: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !addr32 && mod_f == 2'b00 && rm_f == 3'b110)
        |=> (ea == {16'h0, $past(disp[15:0])} && !seg_ss && !is_reg));

    a_r8_no_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && addr32 && mod_f == 2'b00 && rm_f == 3'b100
         && sib_index == 3'b100 && sib_base == 3'b101)
        |=> (ea == $past(disp) && !seg_ss));

    a_r13_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && ea == 32'h0 && !seg_ss && !is_reg));

endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .addr32    (addr32),
    .mod_f     (mod_f),
    .rm_f      (rm_f),
    .sib_index (sib_index),
    .sib_base  (sib_base),
    .disp      (disp),
    .out_valid (out_valid),
    .ea        (ea),
    .seg_ss    (seg_ss),
    .is_reg    (is_reg)
);

// File: tb/tb_ea_gen.sv
`timescale 1ns/100ps
module tb_ea_gen;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         addr32 = 1'b0;
    logic [1:0]   mod_f = '0;
    logic [2:0]   rm_f = '0;
    logic [1:0]   sib_scale = '0;
    logic [2:0]   sib_index = '0;
    logic [2:0]   sib_base = '0;
    logic [31:0]  disp = '0;
    logic [255:0] gpr_flat;
    logic         out_valid;
    logic [31:0]  ea;
    logic         seg_ss;
    logic         is_reg;

    logic [31:0] regs [8];

    typedef struct {
        logic [31:0] addr;
        logic        ss;
        logic        isreg;
        string       tag;
    } exp_t;

    exp_t scb [$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = regs[i];

    ea_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .addr32(addr32),
        .mod_f(mod_f), .rm_f(rm_f), .sib_scale(sib_scale),
        .sib_index(sib_index), .sib_base(sib_base), .disp(disp),
        .gpr_flat(gpr_flat), .out_valid(out_valid), .ea(ea),
        .seg_ss(seg_ss), .is_reg(is_reg)
    );

    // Reference model written from the requirement list
    function automatic exp_t model(bit w32, logic [1:0] md, logic [2:0] rm,
                                   logic [1:0] sc, logic [2:0] ix,
                                   logic [2:0] bs, logic [31:0] d);
        exp_t e;
        e.tag = "";
        if (md == 2'd3) begin
            e.addr = 0; e.ss = 0; e.isreg = 1; e.tag = "R10";
            return e;
        end
        e.isreg = 0;
        if (!w32) begin
            logic [15:0] bx, bp, si, di, a, dd;
            bx = regs[3][15:0]; bp = regs[5][15:0];
            si = regs[6][15:0]; di = regs[7][15:0];
            dd = (md == 2'd1) ? {{8{d[7]}}, d[7:0]} : (md == 2'd2) ? d[15:0] : 16'h0;
            e.ss = 0;
            case (rm)
                0: a = bx + si;
                1: a = bx + di;
                2: begin a = bp + si; e.ss = 1; end
                3: begin a = bp + di; e.ss = 1; end
                4: a = si;
                5: a = di;
                6: if (md == 0) a = d[15:0]; else begin a = bp; e.ss = 1; end
                default: a = bx;
            endcase
            a = a + dd;
            e.addr = {16'h0, a};
            e.tag = (md == 0 && rm == 6) ? "R3" : "R2/R4/R5/R9";
        end else begin
            logic [31:0] a, dd;
            int b;
            bit nob;
            dd = (md == 2'd1) ? {{24{d[7]}}, d[7:0]} : (md == 2'd2) ? d : 32'h0;
            a = 0;
            if (rm != 4) begin
                nob = (rm == 5 && md == 0);
                b = rm;
                e.tag = "R6/R4/R9/R11";
            end else begin
                nob = (bs == 5 && md == 0);
                b = bs;
                if (ix != 4) a = regs[ix] * (32'd1 << sc);
                e.tag = "R7/R8/R9";
            end
            if (nob) a = a + d;
            else     a = a + regs[b];
            a = a + dd;
            e.addr = a;
            e.ss = !nob && (b == 4 || b == 5);
        end
        return e;
    endfunction

    task automatic send(bit w32, logic [1:0] md, logic [2:0] rm, logic [1:0] sc,
                        logic [2:0] ix, logic [2:0] bs, logic [31:0] d);
        @(negedge clk);
        in_valid = 1; addr32 = w32; mod_f = md; rm_f = rm;
        sib_scale = sc; sib_index = ix; sib_base = bs; disp = d;
        scb.push_back(model(w32, md, rm, sc, ix, bs, d));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    // Monitor: compares every valid result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_cmp++;
            if (scb.size() == 0) begin
                n_bad++;
                $display("FAIL R1: result with empty scoreboard, ea=%h exp none", ea);
            end else begin
                exp_t e;
                e = scb.pop_front();
                if (ea !== e.addr || seg_ss !== e.ss || is_reg !== e.isreg) begin
                    n_bad++;
                    $display("FAIL %s: ea=%h ss=%b reg=%b exp ea=%h ss=%b reg=%b",
                             e.tag, ea, seg_ss, is_reg, e.addr, e.ss, e.isreg);
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        regs[0] = 32'hA1B2_0010; regs[1] = 32'h0000_0104;
        regs[2] = 32'h7FFF_0200; regs[3] = 32'h1234_F000;
        regs[4] = 32'h0000_8000; regs[5] = 32'hCAFE_0400;
        regs[6] = 32'h0000_2000; regs[7] = 32'h8000_0030;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(out_valid == 0 && ea == 0 && seg_ss == 0 && is_reg == 0,
            "R13", {28'h0, out_valid, ea[0], seg_ss, is_reg}, 32'h0);
        @(negedge clk);
        rst = 0;

        // R2 R3 R4 R5 R9 R10: every 16-bit form
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 8; r++)
                send(0, m[1:0], r[2:0], 2'd0, 3'd0, 3'd0, 32'h0000_1280);
        // R4: positive disp8 in 16-bit form
        for (int r = 0; r < 8; r++)
            send(0, 2'd1, r[2:0], 2'd0, 3'd0, 3'd0, 32'hFFFF_007F);

        // R6 R10 R11: 32-bit forms without scaled index
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 8; r++)
                if (r != 4) send(1, m[1:0], r[2:0], 2'd0, 3'd0, 3'd0, 32'h8000_FF90);

        // R7 R8 R9: scaled-index forms
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 4; s++)
                for (int x = 0; x < 8; x++) begin
                    send(1, m[1:0], 3'd4, s[1:0], x[2:0], 3'd0, 32'h0001_0081);
                    send(1, m[1:0], 3'd4, s[1:0], x[2:0], 3'd4, 32'h0001_0081);
                    send(1, m[1:0], 3'd4, s[1:0], x[2:0], 3'd5, 32'h0001_0081);
                end

        // R11: carry out of bit 31 is dropped
        regs[3] = 32'hFFFF_FFF0;
        send(1, 2'd2, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0000_0020);
        // R5: 16-bit wrap with changed BX
        send(0, 2'd2, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_E000);

        idle(3);
        begin
            logic [31:0] held_ea;
            logic held_ss, held_reg;
            held_ea = ea; held_ss = seg_ss; held_reg = is_reg;
            // R12: inputs move while in_valid stays low
            @(negedge clk);
            addr32 = 0; mod_f = 2'd3; rm_f = 3'd6; disp = 32'h1234_5678;
            @(negedge clk);
            mod_f = 2'd0;
            @(negedge clk);
            chk(out_valid == 0, "R12", {31'h0, out_valid}, 32'h0);
            chk(ea == held_ea && seg_ss == held_ss && is_reg == held_reg,
                "R12", ea, held_ea);
        end
        chk(scb.size() == 0, "R1", scb.size(), 32'h0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1: watchdog expired, actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule